// File: doc/BRIEF.md
# Line-Scanning Microprogram Sequencer

This block fetches 16-bit microinstructions from a built-in program store and runs one per clock. The program is a service loop for up to sixteen data lines. Each pass through the loop does four things. It steps a 5-bit master line scanner. It copies the low four bits of the scanner into a RAM address register. It reads that line's state byte from an external RAM. It then walks a fixed chain of condition tests. The first condition found true sends control to a short service routine. That routine raises a service pulse, records the scanner value in the RAM, and jumps back to the top of the loop.

The instruction word has four parts. A 3-bit opcode sits in bits 14..12. A 9-bit branch target is formed from bit 15 (as the MSB) and bits 7..0. Bits 11..8 select a condition. Bits 7..4 and 3..0 select a transfer source and destination. The external RAM and the line-side flag sources are plain ports. The RAM is read combinationally through `ram_addr_o` and `ram_rdata_i`.

A two-state machine controls execution:
- ST_BOOT is entered on reset. It holds for exactly one cycle and executes nothing.
- The transition BOOT→RUN is unconditional.
- ST_RUN executes the instruction addressed by the program counter on every cycle.
- Reset is the only path from ST_RUN back to ST_BOOT.

Top module: `lscan_useq`

## Requirements
- R1: While `rst_n` is low, `pc_o` and `scan_o` are zero, and `pulse_valid_o`, `pulse_code_o`, `ram_re_o` and `ram_we_o` are all zero.
- R2: In the first cycle after reset release the machine is in ST_BOOT. In that cycle nothing executes and `pc_o` stays 0. The instruction at address 0 executes in the following cycle.
- R3: Opcode 101 (set/clear) drives `pulse_valid_o` high for one cycle, with `pulse_code_o` equal to bits 7..0. `pulse_code_o` is zero in every other cycle. Code 0x42 increments the 5-bit scanner, which wraps from 31 to 0. No other event changes the scanner.
- R4: Opcode 011 (transfer) puts the source selected by bits 7..4 on an internal bus. Source 5 is the scanner (zero-extended) and source 6 is the RAM data register. The destination selected by bits 3..0 is then loaded: destination 4 takes the low four bits into the RAM address register, and destination 7 takes all eight bits into the write-data register.
- R5: Opcode 010 (RAM) addresses `{bits 3..0, RAM address register}`. When bit 8 is 0, `ram_re_o` is raised and `ram_rdata_i` is latched into the RAM data register at the end of the cycle. When bit 8 is 1, `ram_we_o` is raised with `ram_wdata_o` equal to the write-data register.
- R6: Opcode 000 (branch A) uses bits 11..8 to pick one of 16 conditions. Condition 0 is constant one; condition k (k = 1..15) is `test_i[k-1]`. When the condition is true the PC loads the 9-bit target; otherwise it advances by one.
- R7: Opcode 111 (branch B) tests the bit of the RAM data register selected by bits 10..8. It loads the target when that bit is 1 and advances otherwise.
- R8: The loop occupies addresses 0..9, in this order:
  - 0: scanner step.
  - 1: scanner to address register.
  - 2: read line state (upper nibble 0).
  - 3..8: the priority tests, each branching to its routine when true:

    | Address | Condition | Source | Routine |
    |---|---|---|---|
    | 3 | resync | line-state bit 0 | 0x20 |
    | 4 | transmit go | line-state bit 1 | 0x28 |
    | 5 | transmit flag | `test_i[0]` | 0x30 |
    | 6 | interrupt response | `test_i[1]` | 0x38 |
    | 7 | receive flag | `test_i[2]` | 0x40 |
    | 8 | character waiting | `test_i[3]` | 0x48 |

  - 9: an unconditional jump to 0.

  Flag inputs `test_i[14:4]` have no effect on the loop.
- R9: Service routine k (k = 0..5) starts at 0x20+8k and runs four steps: pulse code 0x10+k, transfer the scanner into the write-data register, RAM write with upper nibble 1, then an unconditional jump to 0. Every unused program location holds a jump to 0.
- R10: Each instruction takes exactly one cycle. `pc_o` shows the address of the instruction now executing. At most one of `pulse_valid_o`, `ram_re_o` and `ram_we_o` is high in any cycle. Non-branch instructions advance the PC by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_i | input | 15 | Branch conditions 1..15 |
| ram_rdata_i | input | 8 | Combinational RAM read data |
| pc_o | output | 9 | Address of the executing instruction |
| scan_o | output | 5 | Master line scanner |
| pulse_valid_o | output | 1 | Set/clear pulse strobe |
| pulse_code_o | output | 8 | Set/clear control code |
| ram_re_o | output | 1 | RAM read strobe |
| ram_we_o | output | 1 | RAM write strobe |
| ram_addr_o | output | 8 | RAM address |
| ram_wdata_o | output | 8 | RAM write data |

## Verification
The bound assertions check three properties on every cycle:
- at most one kind of action happens per cycle;
- the scanner moves only, and always, after a 0x42 pulse;
- the PC advances by one after pulses and RAM accesses.

The loop's behaviour comes from the program contents, so only the bench's reference model can show it. That covers priority among simultaneous conditions, entry to each service routine, the addresses and data of each RAM access, the boot cycle, and the scanner's wrap from 31 to 0. These are exercised through line-state and flag patterns.

// File: rtl/lscan_pkg.sv
package lscan_pkg;

    localparam int WORD_W = 16;
    localparam int PC_W   = 9;
    localparam int SCAN_W = 5;
    localparam int DATA_W = 8;
    localparam int NIB_W  = 4;
    localparam int NCOND  = 16;
    localparam int CSEL_W = $clog2(NCOND);
    localparam int BSEL_W = $clog2(DATA_W);

    typedef enum logic [2:0] {
        OP_BRA    = 3'b000,
        OP_NOP1   = 3'b001,
        OP_RAM    = 3'b010,
        OP_XFR    = 3'b011,
        OP_NOP4   = 3'b100,
        OP_SETCLR = 3'b101,
        OP_NOP6   = 3'b110,
        OP_BRB    = 3'b111
    } opcode_e;

    typedef enum logic {
        ST_BOOT = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    localparam logic [DATA_W-1:0] SC_SCAN_INC = 8'h42;
    localparam logic [DATA_W-1:0] SC_SVC_BASE = 8'h10;
    localparam logic [NIB_W-1:0]  SRC_SCAN    = 4'h5;
    localparam logic [NIB_W-1:0]  SRC_RDATA   = 4'h6;
    localparam logic [NIB_W-1:0]  DST_RADDR   = 4'h4;
    localparam logic [NIB_W-1:0]  DST_WDATA   = 4'h7;

    typedef struct packed {
        logic              pulse_v;
        logic [DATA_W-1:0] pulse_code;
        logic              xfr_v;
        logic [NIB_W-1:0]  src;
        logic [NIB_W-1:0]  dst;
        logic              ram_v;
        logic              ram_wr;
        logic [NIB_W-1:0]  ram_hi;
        logic              br_a;
        logic              br_b;
        logic [CSEL_W-1:0] csel;
        logic [BSEL_W-1:0] bsel;
        logic [PC_W-1:0]   target;
    } ctl_t;

    function automatic logic [WORD_W-1:0] enc_bra(logic [3:0] sel, logic [8:0] tgt);
        return {tgt[8], OP_BRA, sel, tgt[7:0]};
    endfunction

    function automatic logic [WORD_W-1:0] enc_brb(logic [2:0] bit_sel, logic [8:0] tgt);
        return {tgt[8], OP_BRB, 1'b0, bit_sel, tgt[7:0]};
    endfunction

    function automatic logic [WORD_W-1:0] enc_setclr(logic [7:0] code);
        return {1'b0, OP_SETCLR, 4'h0, code};
    endfunction

    function automatic logic [WORD_W-1:0] enc_xfr(logic [3:0] src, logic [3:0] dst);
        return {1'b0, OP_XFR, 4'h0, src, dst};
    endfunction

    function automatic logic [WORD_W-1:0] enc_ram(logic wr, logic [3:0] hi);
        return {1'b0, OP_RAM, 3'b000, wr, 4'h0, hi};
    endfunction

endpackage

// File: rtl/lscan_rom.sv
module lscan_rom
    import lscan_pkg::*;
#(
    parameter int AW    = PC_W,
    parameter int NSVC  = 6,
    parameter int SBASE = 32
) (
    input  logic [AW-1:0]     addr_i,
    output logic [WORD_W-1:0] word_o
);

    localparam int SLOT  = 8;
    localparam int SLAST = SBASE + NSVC * SLOT;

    function automatic logic [WORD_W-1:0] loop_word(logic [3:0] a);
        logic [WORD_W-1:0] w;
        unique case (a)
            4'd0:    w = enc_setclr(SC_SCAN_INC);
            4'd1:    w = enc_xfr(SRC_SCAN, DST_RADDR);
            4'd2:    w = enc_ram(1'b0, 4'h0);
            4'd3:    w = enc_brb(3'd0, 9'(SBASE + 0 * SLOT));
            4'd4:    w = enc_brb(3'd1, 9'(SBASE + 1 * SLOT));
            4'd5:    w = enc_bra(4'd1, 9'(SBASE + 2 * SLOT));
            4'd6:    w = enc_bra(4'd2, 9'(SBASE + 3 * SLOT));
            4'd7:    w = enc_bra(4'd3, 9'(SBASE + 4 * SLOT));
            4'd8:    w = enc_bra(4'd4, 9'(SBASE + 5 * SLOT));
            default: w = enc_bra(4'd0, 9'd0);
        endcase
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] svc_word(logic [2:0] k, logic [2:0] off);
        logic [WORD_W-1:0] w;
        unique case (off)
            3'd0:    w = enc_setclr(SC_SVC_BASE + {5'd0, k});
            3'd1:    w = enc_xfr(SRC_SCAN, DST_WDATA);
            3'd2:    w = enc_ram(1'b1, 4'h1);
            default: w = enc_bra(4'd0, 9'd0);
        endcase
        return w;
    endfunction

    logic [AW-1:0] rel;
    logic          in_loop;
    logic          in_svc;

    always_comb begin
        rel     = addr_i - AW'(SBASE);
        in_loop = (int'(addr_i) < 10);
        in_svc  = (int'(addr_i) >= SBASE) && (int'(addr_i) < SLAST);
        if (in_loop)
            word_o = loop_word(addr_i[3:0]);
        else if (in_svc)
            word_o = svc_word(rel[5:3], rel[2:0]);
        else
            word_o = enc_bra(4'd0, 9'd0);
    end

endmodule

// File: rtl/lscan_decode.sv
module lscan_decode
    import lscan_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output ctl_t              ctl_o
);

    opcode_e op;
    assign op = opcode_e'(word_i[14:12]);

    always_comb begin
        ctl_o        = '0;
        ctl_o.target = {word_i[15], word_i[7:0]};
        unique case (op)
            OP_BRA: begin
                ctl_o.br_a = 1'b1;
                ctl_o.csel = word_i[11:8];
            end
            OP_BRB: begin
                ctl_o.br_b = 1'b1;
                ctl_o.bsel = word_i[10:8];
            end
            OP_RAM: begin
                ctl_o.ram_v  = 1'b1;
                ctl_o.ram_wr = word_i[8];
                ctl_o.ram_hi = word_i[3:0];
            end
            OP_XFR: begin
                ctl_o.xfr_v = 1'b1;
                ctl_o.src   = word_i[7:4];
                ctl_o.dst   = word_i[3:0];
            end
            OP_SETCLR: begin
                ctl_o.pulse_v    = 1'b1;
                ctl_o.pulse_code = word_i[7:0];
            end
            OP_NOP1, OP_NOP4, OP_NOP6: begin
                ctl_o.pulse_v = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lscan_condmux.sv
module lscan_condmux #(
    parameter int NC = 16,
    localparam int SW = $clog2(NC)
) (
    input  logic [NC-2:0] test_i,
    input  logic [SW-1:0] sel_i,
    output logic          cond_o
);

    logic [NC-1:0] pts;

    assign pts[0] = 1'b1;

    for (genvar g = 1; g < NC; g++) begin : g_pt
        assign pts[g] = test_i[g-1];
    end

    assign cond_o = pts[sel_i];

endmodule

// File: rtl/lscan_useq.sv
module lscan_useq
    import lscan_pkg::*;
#(
    parameter int P_PC_W   = PC_W,
    parameter int P_SCAN_W = SCAN_W,
    parameter int P_DATA_W = DATA_W,
    parameter int P_NCOND  = NCOND,
    localparam int AR_W    = NIB_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [P_NCOND-2:0]    test_i,
    input  logic [P_DATA_W-1:0]   ram_rdata_i,
    output logic [P_PC_W-1:0]     pc_o,
    output logic [P_SCAN_W-1:0]   scan_o,
    output logic                  pulse_valid_o,
    output logic [P_DATA_W-1:0]   pulse_code_o,
    output logic                  ram_re_o,
    output logic                  ram_we_o,
    output logic [P_DATA_W-1:0]   ram_addr_o,
    output logic [P_DATA_W-1:0]   ram_wdata_o
);

    seq_state_e            state_q, state_d;
    logic [P_PC_W-1:0]     pc_q;
    logic [P_SCAN_W-1:0]   scan_q;
    logic [AR_W-1:0]       raddr_q;
    logic [P_DATA_W-1:0]   rdata_q;
    logic [P_DATA_W-1:0]   wdata_q;

    logic [WORD_W-1:0]     word;
    ctl_t                  ctl;
    logic                  cond_a;
    logic                  exec;
    logic                  take;
    logic [P_DATA_W-1:0]   xbus;

    lscan_rom #(.AW(P_PC_W)) u_rom (
        .addr_i (pc_q),
        .word_o (word)
    );

    lscan_decode u_dec (
        .word_i (word),
        .ctl_o  (ctl)
    );

    lscan_condmux #(.NC(P_NCOND)) u_cmux (
        .test_i (test_i),
        .sel_i  (ctl.csel),
        .cond_o (cond_a)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_BOOT;
        else
            state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_BOOT: state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
        endcase
    end

    // outputs and per-cycle control
    always_comb begin
        exec          = (state_q == ST_RUN);
        pulse_valid_o = exec && ctl.pulse_v;
        pulse_code_o  = pulse_valid_o ? ctl.pulse_code : '0;
        ram_re_o      = exec && ctl.ram_v && !ctl.ram_wr;
        ram_we_o      = exec && ctl.ram_v && ctl.ram_wr;
        ram_addr_o    = {ctl.ram_hi, raddr_q};
        ram_wdata_o   = wdata_q;
        take          = exec && ((ctl.br_a && cond_a) ||
                                 (ctl.br_b && rdata_q[ctl.bsel]));
    end

    always_comb begin
        case (ctl.src)
            SRC_SCAN:  xbus = {{(P_DATA_W-P_SCAN_W){1'b0}}, scan_q};
            SRC_RDATA: xbus = rdata_q;
            default:   xbus = '0;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q    <= '0;
            scan_q  <= '0;
            raddr_q <= '0;
            rdata_q <= '0;
            wdata_q <= '0;
        end else if (exec) begin
            pc_q <= take ? ctl.target : pc_q + 1'b1;
            if (ctl.pulse_v && ctl.pulse_code == SC_SCAN_INC)
                scan_q <= scan_q + 1'b1;
            if (ctl.xfr_v && ctl.dst == DST_RADDR)
                raddr_q <= xbus[AR_W-1:0];
            if (ctl.xfr_v && ctl.dst == DST_WDATA)
                wdata_q <= xbus;
            if (ctl.ram_v && !ctl.ram_wr)
                rdata_q <= ram_rdata_i;
        end
    end

    assign pc_o   = pc_q;
    assign scan_o = scan_q;

endmodule

// File: rtl/lscan_useq_chk.sv
module lscan_useq_chk #(
    parameter int PC_W   = 9,
    parameter int SCAN_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PC_W-1:0]   pc_o,
    input logic [SCAN_W-1:0] scan_o,
    input logic              pulse_valid_o,
    input logic [7:0]        pulse_code_o,
    input logic              ram_re_o,
    input logic              ram_we_o
);

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({pulse_valid_o, ram_re_o, ram_we_o}) <= 1); // R10

    AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_valid_o && pulse_code_o == 8'h42) |=> scan_o == SCAN_W'($past(scan_o) + 1'b1)); // R3

    AST_SCAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(pulse_valid_o && pulse_code_o == 8'h42) |=> $stable(scan_o)); // R3

    AST_PC_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_valid_o |=> pc_o == PC_W'($past(pc_o) + 1'b1)); // R10

    AST_PC_AFTER_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_re_o || ram_we_o) |=> pc_o == PC_W'($past(pc_o) + 1'b1)); // R5

endmodule

bind lscan_useq lscan_useq_chk #(.PC_W(P_PC_W), .SCAN_W(P_SCAN_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pc_o          (pc_o),
    .scan_o        (scan_o),
    .pulse_valid_o (pulse_valid_o),
    .pulse_code_o  (pulse_code_o),
    .ram_re_o      (ram_re_o),
    .ram_we_o      (ram_we_o)
);

// File: tb/lscan_useq_test.sv
`timescale 1ns/1ps
module lscan_useq_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [14:0] test;
    logic [7:0]  rdata;
    logic [8:0]  pc;
    logic [4:0]  scan;
    logic        pv;
    logic [7:0]  pcode;
    logic        re, we;
    logic [7:0]  addr, wdata;

    always #2.5 clk = ~clk;

    logic [7:0] line_state [16];
    assign rdata = (addr[7:4] == 4'h0) ? line_state[addr[3:0]] : 8'h00;

    lscan_useq uut (
        .clk(clk), .rst_n(rst_n), .test_i(test), .ram_rdata_i(rdata),
        .pc_o(pc), .scan_o(scan), .pulse_valid_o(pv), .pulse_code_o(pcode),
        .ram_re_o(re), .ram_we_o(we), .ram_addr_o(addr), .ram_wdata_o(wdata)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    int m_pc, m_scan, m_ar, m_dr, m_wd;
    bit m_boot;
    int hits [6];
    bit wrap_seen = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // reference model, evaluated once per cycle away from the rising edge
    task automatic model_step();
        string tag;
        int ev = 0, ecode = 0, ere = 0, ewe = 0, eaddr = 0, ewd = 0;
        int n_pc = m_pc + 1, n_scan = m_scan, n_ar = m_ar, n_dr = m_dr, n_wd = m_wd;
        if (m_boot) begin
            tag  = "R2";
            n_pc = 0;
        end else if (m_pc < 10) begin
            case (m_pc)
                0: begin tag = "R3"; ev = 1; ecode = 'h42; n_scan = (m_scan + 1) % 32;
                         if (m_scan == 31) wrap_seen = 1; end
                1: begin tag = "R4"; n_ar = m_scan % 16; end
                2: begin tag = "R5"; ere = 1; eaddr = m_ar; n_dr = line_state[m_ar]; end
                3: begin tag = "R7"; if (m_dr[0]) n_pc = 32; end
                4: begin tag = "R7"; if (m_dr[1]) n_pc = 40; end
                5: begin tag = "R6"; if (test[0]) n_pc = 48; end
                6: begin tag = "R6"; if (test[1]) n_pc = 56; end
                7: begin tag = "R6"; if (test[2]) n_pc = 64; end
                8: begin tag = "R6"; if (test[3]) n_pc = 72; end
                default: begin tag = "R8"; n_pc = 0; end
            endcase
        end else if (m_pc >= 32 && m_pc < 80) begin
            int k = (m_pc - 32) / 8;
            int off = m_pc % 8;
            case (off)
                0: begin tag = "R9"; ev = 1; ecode = 16 + k; hits[k]++; end
                1: begin tag = "R4"; n_wd = m_scan; end
                2: begin tag = "R5"; ewe = 1; eaddr = 16 + m_ar; ewd = m_wd; end
                default: begin tag = "R9"; n_pc = 0; end
            endcase
        end else begin
            tag  = "R9";
            n_pc = 0;
        end

        chk(pc == 9'(m_pc), tag, "pc", pc, m_pc);
        chk(scan == 5'(m_scan), tag, "scanner", scan, m_scan);
        chk(pv == ev[0], tag, "pulse valid", pv, ev);
        chk(pcode == 8'(ecode), tag, "pulse code", pcode, ecode);
        chk(re == ere[0], tag, "read strobe", re, ere);
        chk(we == ewe[0], tag, "write strobe", we, ewe);
        if (ere != 0 || ewe != 0) chk(addr == 8'(eaddr), tag, "ram address", addr, eaddr);
        if (ewe != 0) chk(wdata == 8'(ewd), tag, "write data", wdata, ewd);

        m_boot = 0;
        m_pc = n_pc; m_scan = n_scan; m_ar = n_ar; m_dr = n_dr; m_wd = n_wd;
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            m_boot = 1; m_pc = 0; m_scan = 0; m_ar = 0; m_dr = 0; m_wd = 0;
        end else if (!finished) begin
            model_step();
        end
    end

    task automatic reset_checks();
        @(negedge clk);
        chk(pc == 0, "R1", "pc in reset", pc, 0);
        chk(scan == 0, "R1", "scanner in reset", scan, 0);
        chk(pv == 0 && pcode == 0, "R1", "pulse in reset", pv, 0);
        chk(re == 0 && we == 0, "R1", "ram strobes in reset", {re, we}, 0);
    endtask

    initial begin
        for (int i = 0; i < 6; i++) hits[i] = 0;
        for (int i = 0; i < 16; i++) line_state[i] = 8'h00;
        test  = '0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        reset_checks();
        @(posedge clk); #1 rst_n = 1'b1;

        // idle lines: scanner must pass through 31 and wrap (R3, R8)
        repeat (360) @(posedge clk);
        #1;
        line_state[3] = 8'h01;  // resync on line 3
        line_state[7] = 8'h02;  // transmit go on line 7
        line_state[9] = 8'h03;  // both on line 9: resync has priority (R8)
        repeat (400) @(posedge clk);
        #1 test = 15'h000F;     // transmit flag wins over later flags
        repeat (100) @(posedge clk);
        #1 test = 15'h000E;
        repeat (100) @(posedge clk);
        #1 test = 15'h000C;
        repeat (100) @(posedge clk);
        #1 test = 15'h0008;
        repeat (100) @(posedge clk);
        #1 test = 15'h7FF0;     // unused flags have no effect (R8)
        repeat (100) @(posedge clk);

        // reset during service activity
        #1 rst_n = 1'b0;
        reset_checks();
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (60) @(posedge clk);

        @(negedge clk);
        for (int k = 0; k < 6; k++)
            chk(hits[k] > 0, "R8", "service routine entered", hits[k], 1);
        chk(wrap_seen, "R3", "scanner wrapped 31 to 0", wrap_seen, 1);
        summary();
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R10 watchdog expired: actual hung expected done");
            summary();
            $finish;
        end
    end

endmodule